// File: doc/BRIEF.md
# Receiver Termination Detect Controller

This block is the control logic behind far-end termination detection in an eight-lane PCIe signal conditioner. The lanes are split into two groups. Each group has its own power-down pin, and each decides on its own when to probe the link for a valid receiver termination. While a group has no termination, it keeps its receive common-mode impedance at high impedance. It issues a transmit poll strobe at a fixed interval. In the one cycle after each strobe it samples the analog detector's result. A positive result switches the group to 50 ohm, and the group stays there until the next restart event.

A bypass setting of the pre-decoded mode input turns detection off and pins both groups at 50 ohm. This setting applies only while both power-down pins are low. Holding a power-down pin high forces its group to high impedance and holds it in reset. Once the pin has been held long enough, releasing it starts a fresh detection cycle. Three further events restart detection in every group: leaving reset, a register-write trigger, and any change on the mux select pins. All intervals are given in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `rxterm_detect_ctrl`

## Requirements
- R1: With `mode_lvl` = 2'b00 and both power-down pins low, every `term_50r` bit is 1, no poll strobe fires, no group reports found, and every group status is 2'b00 (idle).
- R2: While `pwr_dn[g]` is 1, group g drives `term_50r[g]` = 0, no poll strobe, and status 2'b11 (reset), whatever the mode level.
- R3: A group that is enabled and not yet found shows status 2'b01 (polling) with `term_50r[g]` = 0. Its strobe lasts one cycle and recurs every POLL_CYC cycles. The first strobe comes two cycles after the restart event is sampled.
- R4: `term_seen[g]` is sampled only in the single cycle after a strobe of that group. A high level at any other time is ignored.
- R5: A sampled positive result makes the group report status 2'b10 (found), `term_found[g]` = 1 and `term_50r[g]` = 1. The group then stops strobing and keeps this state until a restart.
- R6: Holding `pwr_dn[g]` high for at least PD_MIN_CYC cycles and then releasing it clears found and restarts polling in group g.
- R7: A power-down pulse shorter than PD_MIN_CYC cycles does not restart detection. A group that had found a termination reports found again after the pulse.
- R8: Each of these restarts polling in all groups and clears found in the following cycle: leaving reset, a one-cycle `det_trig_wr` pulse, and any change of `mux_sel`.
- R9: Groups are independent: a result, power-down or poll in one group leaves the other group's status unchanged.
- R10: Each of the mode codes 2'b01, 2'b10 and 2'b11 enables detection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_dn | input | NUM_GROUPS | Per-group power-down; bit 0 lanes 0-3, bit 1 lanes 4-7 |
| mode_lvl | input | 2 | Pre-decoded level code; 2'b00 is bypass |
| mux_sel | input | SEL_W | Mux select pins; any change restarts detection |
| det_trig_wr | input | 1 | One-cycle pulse from a write to the detect-trigger register |
| term_seen | input | NUM_GROUPS | Per-group detector result |
| term_50r | output | NUM_GROUPS | Impedance select: 1 = 50 ohm, 0 = high impedance |
| poll_strobe | output | NUM_GROUPS | Per-group transmit detection poll strobe |
| term_found | output | NUM_GROUPS | Group has seen a valid termination |
| grp_status | output | 2*NUM_GROUPS | Per-group status at bits [2g+1:2g]: 00 idle, 01 polling, 10 found, 11 reset |

## Verification
The bench builds the block with CLK_HZ = 100000, which gives one cycle per 10 microseconds. With this setting the 150 microsecond poll interval becomes 15 cycles and the 200 microsecond power-down minimum becomes 20 cycles. Exact poll spacing, the one-cycle sampling window, and both short and long power-down pulses can therefore be checked cycle by cycle in a short run. The default setting of 100 MHz uses the same logic and only makes the counters wider.

// File: rtl/rxterm_pkg.sv
package rxterm_pkg;

    typedef enum logic [1:0] {
        GS_IDLE  = 2'b00,
        GS_POLL  = 2'b01,
        GS_FOUND = 2'b10,
        GS_RESET = 2'b11
    } grp_status_e;

    localparam logic [1:0] MODE_BYPASS = 2'b00;

    function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                                 input int unsigned us);
        return ((clk_hz / 1000) * us) / 1000;
    endfunction

endpackage

// File: rtl/rxterm_restart_gen.sv
module rxterm_restart_gen #(
    parameter int unsigned SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] mux_sel,
    input  logic             det_trig_wr,
    output logic             restart
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             boot;
    } rg_regs_t;

    rg_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.sel  = mux_sel;
        r_d.boot = 1'b0;
        restart  = r_q.boot || det_trig_wr || (mux_sel != r_q.sel);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.sel  <= '0;
            r_q.boot <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/rxterm_pd_hold.sv
module rxterm_pd_hold #(
    parameter int unsigned MIN_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd,
    output logic long_release
);

    localparam int unsigned HW = $clog2(MIN_CYC + 1);
    localparam logic [HW-1:0] SAT = HW'(MIN_CYC);

    typedef struct packed {
        logic [HW-1:0] cnt;
    } ph_regs_t;

    ph_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (pd) begin
            if (r_q.cnt != SAT) begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
        long_release = !pd && (r_q.cnt == SAT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/rxterm_group_ctrl.sv
module rxterm_group_ctrl
    import rxterm_pkg::*;
#(
    parameter int unsigned POLL_CYC = 15
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pd,
    input  logic        bypass,
    input  logic        restart,
    input  logic        det_in,
    output logic        imp_50r,
    output logic        strobe,
    output grp_status_e status
);

    localparam int unsigned TW = (POLL_CYC > 1) ? $clog2(POLL_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(POLL_CYC - 1);

    typedef struct packed {
        logic          found;
        logic [TW-1:0] timer;
        logic          poll;
        logic          sense;
    } gc_regs_t;

    gc_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.poll  = 1'b0;
        r_d.sense = 1'b0;
        if (restart || bypass) begin
            r_d.found = 1'b0;
            r_d.timer = LAST;
        end else if (!pd && !r_q.found) begin
            r_d.timer = (r_q.timer == LAST) ? '0 : r_q.timer + 1'b1;
            r_d.poll  = (r_q.timer == LAST);
            r_d.sense = r_q.poll;
            if (r_q.sense && det_in) begin
                r_d.found = 1'b1;
            end
        end
    end

    always_comb begin
        strobe = r_q.poll && !pd && !bypass;
        if (pd) begin
            imp_50r = 1'b0;
            status  = GS_RESET;
        end else if (bypass) begin
            imp_50r = 1'b1;
            status  = GS_IDLE;
        end else if (r_q.found) begin
            imp_50r = 1'b1;
            status  = GS_FOUND;
        end else begin
            imp_50r = 1'b0;
            status  = GS_POLL;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.found <= 1'b0;
            r_q.timer <= LAST;
            r_q.poll  <= 1'b0;
            r_q.sense <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/rxterm_detect_ctrl.sv
module rxterm_detect_ctrl
    import rxterm_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned POLL_US    = 150,
    parameter int unsigned PD_MIN_US  = 200,
    parameter int unsigned NUM_GROUPS = 2,
    parameter int unsigned SEL_W      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_GROUPS-1:0]   pwr_dn,
    input  logic [1:0]              mode_lvl,
    input  logic [SEL_W-1:0]        mux_sel,
    input  logic                    det_trig_wr,
    input  logic [NUM_GROUPS-1:0]   term_seen,
    output logic [NUM_GROUPS-1:0]   term_50r,
    output logic [NUM_GROUPS-1:0]   poll_strobe,
    output logic [NUM_GROUPS-1:0]   term_found,
    output logic [2*NUM_GROUPS-1:0] grp_status
);

    localparam int unsigned POLL_CYC   = us_to_cycles(CLK_HZ, POLL_US);
    localparam int unsigned PD_MIN_CYC = us_to_cycles(CLK_HZ, PD_MIN_US);

    initial begin
        if (POLL_CYC < 3 || PD_MIN_CYC < 1) begin
            $error("clock too slow for the poll or power-down intervals");
        end
    end

    logic                  restart_all;
    logic                  bypass;
    logic [NUM_GROUPS-1:0] long_rel;
    grp_status_e           st [NUM_GROUPS];

    assign bypass = (mode_lvl == MODE_BYPASS) && (pwr_dn == '0);

    rxterm_restart_gen #(
        .SEL_W(SEL_W)
    ) u_restart (
        .clk        (clk),
        .rst_n      (rst_n),
        .mux_sel    (mux_sel),
        .det_trig_wr(det_trig_wr),
        .restart    (restart_all)
    );

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
        rxterm_pd_hold #(
            .MIN_CYC(PD_MIN_CYC)
        ) u_hold (
            .clk         (clk),
            .rst_n       (rst_n),
            .pd          (pwr_dn[g]),
            .long_release(long_rel[g])
        );

        rxterm_group_ctrl #(
            .POLL_CYC(POLL_CYC)
        ) u_ctrl (
            .clk    (clk),
            .rst_n  (rst_n),
            .pd     (pwr_dn[g]),
            .bypass (bypass),
            .restart(restart_all || long_rel[g]),
            .det_in (term_seen[g]),
            .imp_50r(term_50r[g]),
            .strobe (poll_strobe[g]),
            .status (st[g])
        );

        assign term_found[g]       = (st[g] == GS_FOUND);
        assign grp_status[2*g +: 2] = st[g];
    end

endmodule

// File: rtl/rxterm_detect_ctrl_chk.sv
module rxterm_detect_ctrl_chk #(
    parameter int unsigned NUM_GROUPS = 2
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_GROUPS-1:0]   pwr_dn,
    input logic [1:0]              mode_lvl,
    input logic                    det_trig_wr,
    input logic [NUM_GROUPS-1:0]   term_50r,
    input logic [NUM_GROUPS-1:0]   poll_strobe,
    input logic [NUM_GROUPS-1:0]   term_found,
    input logic [2*NUM_GROUPS-1:0] grp_status
);

    // R1
    bypass_pins_50r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_lvl == 2'b00 && pwr_dn == '0) |->
        (term_50r == '1 && poll_strobe == '0 && term_found == '0));

    // R8
    trig_clears_found_chk: assert property (@(posedge clk) disable iff (!rst_n)
        det_trig_wr |=> (term_found == '0));

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
        // R2
        pd_forces_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pwr_dn[g] |-> (!term_50r[g] && grp_status[2*g +: 2] == 2'b11 && !poll_strobe[g]));

        // R3
        strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            poll_strobe[g] |=> !poll_strobe[g]);

        // R5
        found_holds_50r_chk: assert property (@(posedge clk) disable iff (!rst_n)
            term_found[g] |-> (term_50r[g] && !poll_strobe[g]));

        // R4
        found_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(term_found[g]) && $past(grp_status[2*g +: 2] == 2'b01)) |->
            $past(poll_strobe[g], 2));
    end

endmodule

bind rxterm_detect_ctrl rxterm_detect_ctrl_chk #(
    .NUM_GROUPS(NUM_GROUPS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_dn     (pwr_dn),
    .mode_lvl   (mode_lvl),
    .det_trig_wr(det_trig_wr),
    .term_50r   (term_50r),
    .poll_strobe(poll_strobe),
    .term_found (term_found),
    .grp_status (grp_status)
);

// File: tb/rxterm_detect_ctrl_test.sv
module rxterm_detect_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pwr_dn = 2'b00;
    logic [1:0] mode_lvl = 2'b11;
    logic [1:0] mux_sel = 2'b00;
    logic       det_trig_wr = 1'b0;
    logic [1:0] term_seen = 2'b00;
    logic [1:0] term_50r, poll_strobe, term_found;
    logic [3:0] grp_status;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    rxterm_detect_ctrl #(.CLK_HZ(100_000)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .mode_lvl(mode_lvl),
        .mux_sel(mux_sel), .det_trig_wr(det_trig_wr), .term_seen(term_seen),
        .term_50r(term_50r), .poll_strobe(poll_strobe), .term_found(term_found),
        .grp_status(grp_status)
    );

    // fields: pwr_dn[9:8] mode[7:6] term_50r[5:4] grp_status[3:0]
    localparam logic [9:0] VEC [8] = '{
        {2'b00, 2'b00, 2'b11, 4'b0000},
        {2'b00, 2'b01, 2'b00, 4'b0101},
        {2'b00, 2'b10, 2'b00, 4'b0101},
        {2'b00, 2'b11, 2'b00, 4'b0101},
        {2'b01, 2'b00, 2'b00, 4'b0111},
        {2'b10, 2'b00, 2'b00, 4'b1101},
        {2'b11, 2'b11, 2'b00, 4'b1111},
        {2'b01, 2'b11, 2'b00, 4'b0111}
    };

    task automatic tick();
        @(posedge clk);
        #4;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic wait_strobe0();
        for (int n = 0; n < 40 && !poll_strobe[0]; n++) tick();
    endtask

    task automatic detect0();
        wait_strobe0();
        tick(); term_seen[0] = 1'b1;
        tick(); term_seen[0] = 1'b0;
    endtask

    task automatic pulse_trig();
        det_trig_wr = 1'b1;
        tick();
        det_trig_wr = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int seen;
        repeat (3) tick();
        // reset state, R3
        check("R3 reset status", {30'd0, grp_status[1:0]}, 32'h1);
        check("R3 reset imp", {30'd0, term_50r}, 32'h0);
        check("R5 reset found", {30'd0, term_found}, 32'h0);
        rst_n = 1'b1;
        tick();
        check("R8 power-up no early strobe", {31'd0, poll_strobe[0]}, 32'h0);
        tick();
        check("R8 power-up first strobe", {31'd0, poll_strobe[0]}, 32'h1);

        // R3 period
        seen = 0;
        for (int i = 1; i < 15; i++) begin
            tick();
            if (poll_strobe[0]) seen++;
        end
        check("R3 no strobe inside interval", seen, 0);
        tick();
        check("R3 strobe after interval", {31'd0, poll_strobe[0]}, 32'h1);

        // table of static patterns: R1 R2 R10
        for (int v = 0; v < 8; v++) begin
            pwr_dn   = VEC[v][9:8];
            mode_lvl = VEC[v][7:6];
            pulse_trig();
            tick();
            check("R1/R2/R10 imp", {30'd0, term_50r}, {30'd0, VEC[v][5:4]});
            check("R1/R2/R10 status", {28'd0, grp_status}, {28'd0, VEC[v][3:0]});
        end

        // R1 bypass: no strobes
        pwr_dn = 2'b00; mode_lvl = 2'b00;
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (poll_strobe != 2'b00) seen++;
        end
        check("R1 bypass no strobe", seen, 0);
        mode_lvl = 2'b11;
        tick();

        // R4: result outside the sampling cycle is ignored
        wait_strobe0();
        term_seen[0] = 1'b1;
        tick(); term_seen[0] = 1'b0;
        tick(); term_seen[0] = 1'b1;
        repeat (10) tick();
        term_seen[0] = 1'b0;
        check("R4 ignored result found", {31'd0, term_found[0]}, 32'h0);
        check("R4 ignored result status", {30'd0, grp_status[1:0]}, 32'h1);

        // R5 detection
        detect0();
        check("R5 found", {31'd0, term_found[0]}, 32'h1);
        check("R5 imp 50", {31'd0, term_50r[0]}, 32'h1);
        check("R5 status", {30'd0, grp_status[1:0]}, 32'h2);
        check("R9 other group polling", {30'd0, grp_status[3:2]}, 32'h1);
        seen = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (poll_strobe[0]) seen++;
        end
        check("R5 no strobe after found", seen, 0);
        check("R5 found persists", {31'd0, term_found[0]}, 32'h1);

        // R7 short power-down pulse
        pwr_dn[0] = 1'b1;
        #1;
        check("R2 pd forces hiz", {31'd0, term_50r[0]}, 32'h0);
        check("R2 pd status", {30'd0, grp_status[1:0]}, 32'h3);
        check("R9 other group during pd", {30'd0, grp_status[3:2]}, 32'h1);
        repeat (5) tick();
        pwr_dn[0] = 1'b0;
        tick();
        check("R7 short pulse keeps found", {31'd0, term_found[0]}, 32'h1);

        // R6 long power-down pulse
        pwr_dn[0] = 1'b1;
        repeat (25) tick();
        pwr_dn[0] = 1'b0;
        tick();
        check("R6 long pulse clears found", {31'd0, term_found[0]}, 32'h0);
        check("R6 long pulse polling", {30'd0, grp_status[1:0]}, 32'h1);

        // R8 trigger write
        detect0();
        check("R8 found before trigger", {31'd0, term_found[0]}, 32'h1);
        pulse_trig();
        check("R8 trigger clears found", {31'd0, term_found[0]}, 32'h0);

        // R8 mux select change
        detect0();
        check("R8 found before sel change", {31'd0, term_found[0]}, 32'h1);
        mux_sel = 2'b10;
        tick();
        check("R8 sel change clears found", {31'd0, term_found[0]}, 32'h0);
        tick();
        check("R8 sel change restarts strobe", {31'd0, poll_strobe[0]}, 32'h1);

        summary();
        $finish;
    end

endmodule